// File: doc/BRIEF.md
# Integer Logical Unit with Record Form

This block is the combinational logical path of a 32-bit integer execution pipe. From a decoded operation code it combines a source word S with either a second register word B or a 16-bit unsigned immediate. The bit-parallel operations are AND, AND with complement, NAND, NOR and equivalence. Two immediate AND forms are included: one uses the immediate in the low half, and the other uses it in the upper half. The unit also counts the leading zeros of S and sign-extends the low byte or the low halfword of S. The 32-bit result appears in the same cycle as the operands.

A record flag marks the operation as one that also updates condition field 0. When that field is written, it describes the result as negative, positive or zero, and it carries the current summary-overflow bit. The two immediate AND forms always write the field. The unit has no path to the overflow, carry or summary-overflow bits of the exception register, so it never changes them. Decode, the register file and exception handling are outside this block.

Top module: `int_logic_unit`

## Requirements
- R1: With op_i 0 the result is S & B, with 1 S & ~B, with 2 ~(S & B), with 3 ~(S | B) and with 4 ~(S ^ B).
- R2: With op_i 5 the result is S AND the immediate zero-extended to 32 bits.
- R3: With op_i 6 the result is S AND {immediate, 16'h0000}.
- R4: With op_i 7 the result is the number of leading zero bits of S, from bit 31 downwards, and it is 32 when S is zero.
- R5: With op_i 8 the result is S[7:0] with bit 7 copied into bits 31:8, and with op_i 9 it is S[15:0] with bit 15 copied into bits 31:16.
- R6: For op_i 0 to 4 and 7 to 9, cr0_we_o equals rec_i.
- R7: For op_i 5 and 6, cr0_we_o is 1 whatever rec_i is.
- R8: cr0_o[3] (LT) is 1 when the result is negative as a signed number, cr0_o[2] (GT) is 1 when it is positive, and cr0_o[1] (EQ) is 1 when it is zero.
- R9: cr0_o[0] (SO) always equals so_i.
- R10: Codes 10 to 15 give a zero result and cr0_we_o 0.
- R11: imm_i has no effect on the result for op_i 0 to 4 and 7 to 9, and src_b_i has no effect on the result for op_i 5 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| rec_i | input | 1 | Record flag: request a condition field 0 update |
| src_s_i | input | 32 | Source word S |
| src_b_i | input | 32 | Second register word B |
| imm_i | input | 16 | Unsigned immediate |
| so_i | input | 1 | Current summary-overflow bit |
| result_o | output | 32 | Operation result |
| cr0_we_o | output | 1 | Write enable for condition field 0 |
| cr0_o | output | 4 | Condition field 0 as {LT, GT, EQ, SO} |

## Verification
The assertions are immediate checks evaluated inside each submodule. They assume the operands are settled, 2-state values whenever the combinational logic is evaluated. The bench drives every input, including the initial zero state, and changes the inputs only just after a rising clock edge. It reads the outputs at the falling edge, when all of them have settled. The stimulus uses every operation code, unused codes included, and pairs the immediate forms with rec_i at both 0 and 1.

// File: rtl/int_logic_pkg.sv
package int_logic_pkg;
   typedef enum logic [3:0] {
      LOP_AND   = 4'd0,
      LOP_ANDC  = 4'd1,
      LOP_NAND  = 4'd2,
      LOP_NOR   = 4'd3,
      LOP_EQV   = 4'd4,
      LOP_ANDI  = 4'd5,
      LOP_ANDIS = 4'd6,
      LOP_CLZ   = 4'd7,
      LOP_EXTB  = 4'd8,
      LOP_EXTH  = 4'd9
   } lop_e;

   typedef enum logic [1:0] {
      RSEL_LOGIC = 2'd0,
      RSEL_CLZ   = 2'd1,
      RSEL_EXT   = 2'd2,
      RSEL_NONE  = 2'd3
   } rsel_e;
endpackage

// File: rtl/lu_bitwise.sv
module lu_bitwise
   import int_logic_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  lop_e             op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] y_o
);
   always_comb begin
      unique case (op_i)
         LOP_AND, LOP_ANDI, LOP_ANDIS: y_o = a_i & b_i;
         LOP_ANDC: y_o = a_i & ~b_i;
         LOP_NAND: y_o = ~(a_i & b_i);
         LOP_NOR:  y_o = ~(a_i | b_i);
         LOP_EQV:  y_o = ~(a_i ^ b_i);
         default:  y_o = '0;
      endcase
   end
endmodule

// File: rtl/lu_clz.sv
module lu_clz #(
   parameter int WIDTH    = 32,
   parameter bit USE_TREE = 1'b1,
   localparam int LEVELS  = $clog2(WIDTH),
   localparam int CNT_W   = LEVELS + 1
) (
   input  logic [WIDTH-1:0] x_i,
   output logic [CNT_W-1:0] cnt_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("lu_clz: WIDTH must be at least 2");
   end

   if (USE_TREE) begin : g_tree
      if ((1 << LEVELS) != WIDTH) begin : g_bad_pow2
         $error("lu_clz: tree variant needs a power-of-two WIDTH");
      end
      logic [WIDTH-1:0]  stage [0:LEVELS];
      logic [LEVELS-1:0] zbits;
      assign stage[0] = x_i;
      for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
         localparam int K    = LEVELS - 1 - g;
         localparam int SPAN = 1 << K;
         assign zbits[K]     = (stage[g][WIDTH-1 -: SPAN] == '0);
         assign stage[g+1]   = zbits[K] ? (stage[g] << SPAN) : stage[g];
      end
      assign cnt_o = {1'b0, zbits} + CNT_W'(!stage[LEVELS][WIDTH-1]);
   end else begin : g_scan
      always_comb begin
         cnt_o = CNT_W'(WIDTH);
         for (int i = 0; i < WIDTH; i++) begin
            if (x_i[i]) cnt_o = CNT_W'(WIDTH - 1 - i);
         end
      end
   end

   always_comb begin
      // R4
      clz_zero_chk: assert ((int'(cnt_o) == WIDTH) == (x_i == '0))
         else $error("clz count and zero word disagree");
      if (int'(cnt_o) < WIDTH) begin
         // R4
         clz_lead_chk: assert (x_i[WIDTH - 1 - int'(cnt_o)])
            else $error("clz count does not point at a set bit");
      end
   end
endmodule

// File: rtl/lu_sext.sv
module lu_sext #(
   parameter int WIDTH  = 32,
   parameter int FROM_W = 8
) (
   input  logic [FROM_W-1:0] x_i,
   output logic [WIDTH-1:0]  y_o
);
   if (FROM_W < 1 || FROM_W >= WIDTH) begin : g_bad
      $error("lu_sext: FROM_W must lie in 1..WIDTH-1");
   end

   assign y_o = {{(WIDTH-FROM_W){x_i[FROM_W-1]}}, x_i};

   always_comb begin
      // R5
      sext_fill_chk: assert ((&y_o[WIDTH-1:FROM_W-1]) || !(|y_o[WIDTH-1:FROM_W-1]))
         else $error("sign fill is not uniform");
   end
endmodule

// File: rtl/lu_cr0.sv
module lu_cr0 #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res_i,
   input  logic             so_i,
   output logic [3:0]       cr_o
);
   logic neg, zero;
   assign neg  = res_i[WIDTH-1];
   assign zero = (res_i == '0);
   assign cr_o = {neg, !neg && !zero, zero, so_i};

   always_comb begin
      // R8
      cr0_onehot_chk: assert ($onehot(cr_o[3:1]))
         else $error("condition field must flag exactly one of LT/GT/EQ");
   end
endmodule

// File: rtl/int_logic_unit.sv
module int_logic_unit
   import int_logic_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int IMM_W    = 16,
   parameter bit CLZ_TREE = 1'b1,
   localparam int CNT_W   = $clog2(WIDTH) + 1
) (
   input  logic [3:0]       op_i,
   input  logic             rec_i,
   input  logic [WIDTH-1:0] src_s_i,
   input  logic [WIDTH-1:0] src_b_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             so_i,
   output logic [WIDTH-1:0] result_o,
   output logic             cr0_we_o,
   output logic [3:0]       cr0_o
);
   if (WIDTH != 2 * IMM_W) begin : g_bad_imm
      $error("int_logic_unit: WIDTH must be twice IMM_W");
   end
   if (WIDTH <= 16) begin : g_bad_w
      $error("int_logic_unit: WIDTH must exceed 16 for halfword extension");
   end

   lop_e             op;
   rsel_e            rsel;
   logic             imm_form;
   logic [WIDTH-1:0] opnd_b;
   logic [WIDTH-1:0] logic_y, clz_y, extb_y, exth_y;
   logic [CNT_W-1:0] clz_cnt;

   assign op = lop_e'(op_i);

   always_comb begin
      imm_form = 1'b0;
      case (op)
         LOP_AND, LOP_ANDC, LOP_NAND, LOP_NOR, LOP_EQV: rsel = RSEL_LOGIC;
         LOP_ANDI, LOP_ANDIS: begin
            rsel     = RSEL_LOGIC;
            imm_form = 1'b1;
         end
         LOP_CLZ:            rsel = RSEL_CLZ;
         LOP_EXTB, LOP_EXTH: rsel = RSEL_EXT;
         default:            rsel = RSEL_NONE;
      endcase
   end

   always_comb begin
      case (op)
         LOP_ANDI:  opnd_b = {{IMM_W{1'b0}}, imm_i};
         LOP_ANDIS: opnd_b = {imm_i, {IMM_W{1'b0}}};
         default:   opnd_b = src_b_i;
      endcase
   end

   lu_bitwise #(.WIDTH(WIDTH)) i_bitwise (
      .op_i (op),
      .a_i  (src_s_i),
      .b_i  (opnd_b),
      .y_o  (logic_y)
   );

   lu_clz #(.WIDTH(WIDTH), .USE_TREE(CLZ_TREE)) i_clz (
      .x_i   (src_s_i),
      .cnt_o (clz_cnt)
   );
   assign clz_y = WIDTH'(clz_cnt);

   lu_sext #(.WIDTH(WIDTH), .FROM_W(8)) i_extb (
      .x_i (src_s_i[7:0]),
      .y_o (extb_y)
   );

   lu_sext #(.WIDTH(WIDTH), .FROM_W(16)) i_exth (
      .x_i (src_s_i[15:0]),
      .y_o (exth_y)
   );

   always_comb begin
      case (rsel)
         RSEL_LOGIC: result_o = logic_y;
         RSEL_CLZ:   result_o = clz_y;
         RSEL_EXT:   result_o = (op == LOP_EXTB) ? extb_y : exth_y;
         default:    result_o = '0;
      endcase
   end

   assign cr0_we_o = (rsel != RSEL_NONE) && (rec_i || imm_form);

   lu_cr0 #(.WIDTH(WIDTH)) i_cr0 (
      .res_i (result_o),
      .so_i  (so_i),
      .cr_o  (cr0_o)
   );
endmodule

// File: tb/test_int_logic_unit.sv
module test_int_logic_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = 4'd0;
   logic        rec = 1'b0;
   logic [31:0] s = 32'd0;
   logic [31:0] b = 32'd0;
   logic [15:0] imm = 16'd0;
   logic        so = 1'b0;
   logic [31:0] res;
   logic        we;
   logic [3:0]  cr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string       tag;
      logic [31:0] res;
      logic        we;
      logic [3:0]  cr;
   } item_t;

   item_t sb[$];

   always #2.5 clk = ~clk;

   int_logic_unit i_int_logic_unit (
      .op_i(op), .rec_i(rec), .src_s_i(s), .src_b_i(b), .imm_i(imm),
      .so_i(so), .result_o(res), .cr0_we_o(we), .cr0_o(cr)
   );

   function automatic int clz_ref(input logic [31:0] x);
      for (int i = 31; i >= 0; i--) if (x[i]) return 31 - i;
      return 32;
   endfunction

   function automatic item_t model(input string tag, input logic [3:0] o, input logic r,
                                   input logic [31:0] xs, input logic [31:0] xb,
                                   input logic [15:0] xi, input logic xso);
      item_t e;
      e.tag = tag;
      case (o)
         4'd0: e.res = xs & xb;
         4'd1: e.res = xs & ~xb;
         4'd2: e.res = ~(xs & xb);
         4'd3: e.res = ~(xs | xb);
         4'd4: e.res = ~(xs ^ xb);
         4'd5: e.res = xs & {16'h0000, xi};
         4'd6: e.res = xs & {xi, 16'h0000};
         4'd7: e.res = clz_ref(xs);
         4'd8: e.res = {{24{xs[7]}}, xs[7:0]};
         4'd9: e.res = {{16{xs[15]}}, xs[15:0]};
         default: e.res = 32'd0;
      endcase
      if (o > 4'd9)                    e.we = 1'b0;
      else if (o == 4'd5 || o == 4'd6) e.we = 1'b1;
      else                             e.we = r;
      e.cr = {$signed(e.res) < 0, $signed(e.res) > 0, e.res == 32'd0, xso};
      return e;
   endfunction

   task automatic drive(input string tag, input logic [3:0] o, input logic r,
                        input logic [31:0] xs, input logic [31:0] xb,
                        input logic [15:0] xi, input logic xso);
      @(posedge clk);
      #1;
      op = o; rec = r; s = xs; b = xb; imm = xi; so = xso;
      sb.push_back(model(tag, o, r, xs, xb, xi, xso));
   endtask

   always @(negedge clk) begin
      if (rst_n && sb.size() > 0) begin
         item_t e;
         e = sb.pop_front();
         checks++;
         if (res !== e.res || we !== e.we || cr !== e.cr) begin
            fails++;
            $display("FAIL %s: res=%h we=%b cr=%b expected res=%h we=%b cr=%b",
                     e.tag, res, we, cr, e.res, e.we, e.cr);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state: all-zero inputs give AND = 0, EQ set, no write (R8)
      drive("R8", 4'd0, 1'b0, 32'd0, 32'd0, 16'd0, 1'b0);
      // R1 logic forms
      drive("R1", 4'd0, 1'b1, 32'hFFFF0000, 32'h0FF00FF0, 16'h1234, 1'b0);
      drive("R1", 4'd1, 1'b0, 32'hFFFF0000, 32'h0FF00FF0, 16'h1234, 1'b0);
      drive("R1", 4'd2, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 1'b0);
      drive("R1", 4'd3, 1'b1, 32'h00000000, 32'h00000001, 16'h0, 1'b1);
      drive("R1", 4'd4, 1'b1, 32'hA5A5A5A5, 32'hA5A5A5A5, 16'h0, 1'b0);
      // R2 / R7 immediate low, record off still writes
      drive("R2", 4'd5, 1'b0, 32'hFFFFFFFF, 32'h0, 16'h8001, 1'b0);
      drive("R7", 4'd5, 1'b1, 32'hFFFF0000, 32'hFFFFFFFF, 16'hFFFF, 1'b1);
      // R3 shifted immediate, negative result
      drive("R3", 4'd6, 1'b0, 32'h80001234, 32'h0, 16'hFFFF, 1'b0);
      drive("R7", 4'd6, 1'b0, 32'h00FFFFFF, 32'h0, 16'h0100, 1'b0);
      // R4 leading zeros
      drive("R4", 4'd7, 1'b1, 32'h00000000, 32'h0, 16'h0, 1'b0);
      drive("R4", 4'd7, 1'b1, 32'h00000001, 32'h0, 16'h0, 1'b0);
      drive("R4", 4'd7, 1'b1, 32'h80000000, 32'h0, 16'h0, 1'b0);
      drive("R4", 4'd7, 1'b0, 32'h00010000, 32'h0, 16'h0, 1'b0);
      // R5 sign extension
      drive("R5", 4'd8, 1'b1, 32'h12345680, 32'h0, 16'h0, 1'b0);
      drive("R5", 4'd8, 1'b1, 32'hFFFFFF7F, 32'h0, 16'h0, 1'b0);
      drive("R5", 4'd9, 1'b1, 32'h00008000, 32'h0, 16'h0, 1'b0);
      drive("R5", 4'd9, 1'b0, 32'hFFFF7FFF, 32'h0, 16'h0, 1'b0);
      // R6 record flag on register forms
      drive("R6", 4'd3, 1'b0, 32'h0, 32'h0, 16'h0, 1'b1);
      drive("R6", 4'd7, 1'b1, 32'h0000FFFF, 32'h0, 16'h0, 1'b0);
      // R9 SO mirrors input
      drive("R9", 4'd2, 1'b1, 32'h0, 32'h0, 16'h0, 1'b1);
      drive("R9", 4'd8, 1'b0, 32'h80, 32'h0, 16'h0, 1'b1);
      // R10 unused codes
      for (int c = 10; c < 16; c++)
         drive("R10", 4'(c), 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 1'b0);
      // R11 ignored operands: vary imm on register forms, B on others
      drive("R11", 4'd0, 1'b1, 32'hF0F0F0F0, 32'h3C3C3C3C, 16'hFFFF, 1'b0);
      drive("R11", 4'd0, 1'b1, 32'hF0F0F0F0, 32'h3C3C3C3C, 16'h0000, 1'b0);
      drive("R11", 4'd5, 1'b0, 32'h0000F0F0, 32'hFFFFFFFF, 16'h0FF0, 1'b0);
      drive("R11", 4'd5, 1'b0, 32'h0000F0F0, 32'h00000000, 16'h0FF0, 1'b0);
      drive("R11", 4'd7, 1'b0, 32'h00000F00, 32'hFFFFFFFF, 16'hFFFF, 1'b0);
      drive("R11", 4'd9, 1'b0, 32'h0000F000, 32'h12345678, 16'hABCD, 1'b0);
      // mixed patterns across all codes
      for (int n = 0; n < 400; n++) begin
         logic [31:0] rs;
         logic [3:0]  ro;
         rs = $urandom;
         if (n % 5 == 0) rs = rs >> (n % 32);
         ro = 4'(n % 16);
         drive("R1", ro, 1'($urandom), rs, $urandom, 16'($urandom), 1'($urandom));
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule